// File: doc/BRIEF.md
# Slot Power and Reset Sequencer

This block controls one downstream hot-plug slot. It drives the slot's power enable output and its active-low port reset output, and it keeps the two in a fixed order. On power-up the power enable goes high first. Reset is released only after a programmable wait. On power-down reset is asserted first, and the power enable drops only after a second programmable wait. All waits are counted in ticks from a parameterised clock divider. With the default divider and a 100 MHz clock, one tick is 1 µs.

Two sequencing modes are selected by an input. In the power-enable mode the power-up wait starts as soon as power is enabled, and the slot's power-good input is ignored. In the power-good mode the power-up wait starts only once the slot's active-low power-good input reports good, after a two-flop synchronizer. In this mode, losing power good while the slot is on asserts reset again.

Reset is also asserted on a fundamental reset and on a reset request caused by a port operating-mode change. Every low period of the reset output lasts at least a parameterised number of ticks, whatever caused it. A status output shows when the slot is fully on.

Top module: `slot_pwr_seq`

## Requirements
- R1: While `pwr_en` is low, `port_rst_n` is low. After block reset, `pwr_en`, `port_rst_n` and `slot_on` are all 0.
- R2: `pwr_ctl_off` = 0 requests slot power on and 1 requests power off. From the off state, a power-on request raises `pwr_en` one clock after it is sampled.
- R3: With `mode_pg` = 0, `port_rst_n` rises between N×TICK_DIV and (N+1)×TICK_DIV+4 clocks after `pwr_en` rises, where N is `dly_pwr2rst`. In this mode `pwr_good_n` has no effect on the release.
- R4: A power-off request drives `port_rst_n` low one clock after it is sampled. `pwr_en` then falls between M×TICK_DIV and (M+1)×TICK_DIV+4 clocks later, where M is `dly_rst2pwr`.
- R5: With `mode_pg` = 1, reset is not released while `pwr_good_n` is high. The power-to-reset wait starts after `pwr_good_n` goes low, passes through a two-flop synchronizer, and takes N tick periods as in R3.
- R6: With `mode_pg` = 1 and the slot on, `pwr_good_n` going high drives `port_rst_n` low within 5 clocks. `pwr_en` stays high.
- R7: In either mode, `fund_rst` and `opmode_rst_req` each drive `port_rst_n` low one clock after they are sampled high. Reset stays low while `fund_rst` is held, and neither input changes `pwr_en`.
- R8: Every low period of `port_rst_n` lasts at least MIN_RST_TICKS×TICK_DIV clocks. After the last reset cause, the release comes within (MIN_RST_TICKS+1)×TICK_DIV+6 clocks.
- R9: A power-off request made while power-up is still in progress aborts it. Reset is never released, and `pwr_en` falls after the reset-to-power wait.
- R10: `slot_on` is 1 exactly while `port_rst_n` is 1.
- R11: A delay field value of 0 gives a wait of a single tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pwr_ctl_off | input | 1 | Slot power control bit: 0 = power on, 1 = power off |
| mode_pg | input | 1 | Sequencing mode: 0 = power-enable, 1 = power-good |
| dly_pwr2rst | input | DLY_W | Power-on to reset-release wait, in ticks (value + 1 ticks) |
| dly_rst2pwr | input | DLY_W | Reset-assert to power-off wait, in ticks (value + 1 ticks) |
| pwr_good_n | input | 1 | Slot supply power good, active low, asynchronous |
| fund_rst | input | 1 | Fundamental reset, active high, held for its duration |
| opmode_rst_req | input | 1 | Single-cycle reset request from an operating-mode change |
| pwr_en | output | 1 | Slot power enable |
| port_rst_n | output | 1 | Downstream port reset, active low |
| slot_on | output | 1 | Slot fully powered with reset released |

## Verification
The bench times each edge of the power enable and reset outputs against windows derived from the tick period. A design that swapped the power-up or power-down ordering, or counted the delay fields one tick short, would show an edge in the wrong order or outside its window. The bench also targets:
- the minimum reset width after a one-cycle operating-mode request and after a held fundamental reset, where a design that released early or timed from the wrong cause would show a short pulse;
- the power-good gate in both modes, where a design that ignored or misused power good would release reset with no supply or hang waiting for it;
- power-off aborting a power-up that is still waiting, where a faulty sequencer would show a stray reset release.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  typedef enum logic [2:0] {
    SQ_OFF      = 3'd0,
    SQ_WAIT_PG  = 3'd1,
    SQ_PWR_DLY  = 3'd2,
    SQ_ON       = 3'd3,
    SQ_OFF_DLY  = 3'd4,
    SQ_RST_HOLD = 3'd5
  } seq_state_e;

  typedef enum logic {
    DSEL_PWR2RST = 1'b0,
    DSEL_RST2PWR = 1'b1
  } dly_sel_e;

endpackage

// File: rtl/slot_tick_gen.sv
module slot_tick_gen #(
  parameter int TICK_DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] div_q, div_d;

  always_comb begin
    if (div_q == LAST) div_d = '0;
    else               div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/slot_dly_cnt.sv
module slot_dly_cnt #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             done
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load | (tick & (cnt_q != '0));

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // a value of N completes on the (N+1)th tick after the load
  assign done = tick & ~load & (cnt_q == '0);
endmodule

// File: rtl/slot_rst_age.sv
module slot_rst_age #(
  parameter int MIN_RST_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic age_done
);
  localparam int TARGET = MIN_RST_TICKS + 1;
  localparam int AW     = $clog2(TARGET + 1);
  localparam logic [AW-1:0] TGT = AW'(TARGET);

  logic [AW-1:0] age_q, age_d;
  logic          age_en;

  assign age_done = (age_q == TGT);
  assign age_en   = clr | (tick & ~age_done);

  always_comb begin
    if (clr) age_d = '0;
    else     age_d = age_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age_q <= '0;
    else if (age_en) age_q <= age_d;
  end
endmodule

// File: rtl/slot_seq_fsm.sv
module slot_seq_fsm
  import slot_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     off_req,
  input  logic     mode_pg,
  input  logic     pg_ok_sync,
  input  logic     ext_rst,
  input  logic     dly_done,
  input  logic     age_done,
  output logic     dly_load,
  output dly_sel_e dly_sel,
  output logic     age_clr,
  output logic     pwr_en,
  output logic     port_rst_n,
  output logic     slot_on
);
  seq_state_e st_q, st_d;
  logic       pg_ok;
  logic       may_release;

  // in power-enable mode the supply is treated as always good
  assign pg_ok       = ~mode_pg | pg_ok_sync;
  assign may_release = age_done & ~ext_rst;

  always_comb begin
    st_d     = st_q;
    dly_load = 1'b0;
    dly_sel  = DSEL_PWR2RST;
    unique case (st_q)
      SQ_OFF: begin
        if (!off_req) begin
          if (pg_ok) begin
            st_d     = SQ_PWR_DLY;
            dly_load = 1'b1;
          end else begin
            st_d = SQ_WAIT_PG;
          end
        end
      end
      SQ_WAIT_PG: begin
        if (off_req) begin
          st_d     = SQ_OFF_DLY;
          dly_load = 1'b1;
          dly_sel  = DSEL_RST2PWR;
        end else if (pg_ok) begin
          st_d     = SQ_PWR_DLY;
          dly_load = 1'b1;
        end
      end
      SQ_PWR_DLY: begin
        if (off_req) begin
          st_d     = SQ_OFF_DLY;
          dly_load = 1'b1;
          dly_sel  = DSEL_RST2PWR;
        end else if (!pg_ok) begin
          st_d = SQ_WAIT_PG;
        end else if (dly_done) begin
          st_d = may_release ? SQ_ON : SQ_RST_HOLD;
        end
      end
      SQ_RST_HOLD: begin
        if (off_req) begin
          st_d     = SQ_OFF_DLY;
          dly_load = 1'b1;
          dly_sel  = DSEL_RST2PWR;
        end else if (!pg_ok) begin
          st_d = SQ_WAIT_PG;
        end else if (may_release) begin
          st_d = SQ_ON;
        end
      end
      SQ_ON: begin
        if (off_req) begin
          st_d     = SQ_OFF_DLY;
          dly_load = 1'b1;
          dly_sel  = DSEL_RST2PWR;
        end else if (ext_rst) begin
          st_d = SQ_RST_HOLD;
        end else if (!pg_ok) begin
          st_d = SQ_WAIT_PG;
        end
      end
      SQ_OFF_DLY: begin
        if (dly_done) st_d = SQ_OFF;
      end
      default: st_d = SQ_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_OFF;
    else        st_q <= st_d;
  end

  // the age restarts while reset is released and on every new cause
  assign age_clr    = (st_q == SQ_ON) | ext_rst;
  assign pwr_en     = (st_q != SQ_OFF);
  assign port_rst_n = (st_q == SQ_ON);
  assign slot_on    = (st_q == SQ_ON);
endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq
  import slot_seq_pkg::*;
#(
  parameter int TICK_DIV      = 100,
  parameter int MIN_RST_TICKS = 200,
  parameter int DLY_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_ctl_off,
  input  logic             mode_pg,
  input  logic [DLY_W-1:0] dly_pwr2rst,
  input  logic [DLY_W-1:0] dly_rst2pwr,
  input  logic             pwr_good_n,
  input  logic             fund_rst,
  input  logic             opmode_rst_req,
  output logic             pwr_en,
  output logic             port_rst_n,
  output logic             slot_on
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] pg_sync_q;
  logic                   tick;
  logic                   dly_load, dly_done;
  dly_sel_e               dly_sel;
  logic [DLY_W-1:0]       dly_val;
  logic                   age_clr, age_done;
  logic                   ext_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_sync_q <= '0;
    else        pg_sync_q <= {pg_sync_q[SYNC_STAGES-2:0], ~pwr_good_n};
  end

  assign ext_rst = fund_rst | opmode_rst_req;
  assign dly_val = (dly_sel == DSEL_RST2PWR) ? dly_rst2pwr : dly_pwr2rst;

  slot_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  slot_dly_cnt #(.DLY_W(DLY_W)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .load    (dly_load),
    .load_val(dly_val),
    .done    (dly_done)
  );

  slot_rst_age #(.MIN_RST_TICKS(MIN_RST_TICKS)) u_age (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .clr     (age_clr),
    .age_done(age_done)
  );

  slot_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .off_req   (pwr_ctl_off),
    .mode_pg   (mode_pg),
    .pg_ok_sync(pg_sync_q[SYNC_STAGES-1]),
    .ext_rst   (ext_rst),
    .dly_done  (dly_done),
    .age_done  (age_done),
    .dly_load  (dly_load),
    .dly_sel   (dly_sel),
    .age_clr   (age_clr),
    .pwr_en    (pwr_en),
    .port_rst_n(port_rst_n),
    .slot_on   (slot_on)
  );
endmodule

// File: rtl/slot_pwr_seq_chk.sv
module slot_pwr_seq_chk #(
  parameter int TICK_DIV      = 100,
  parameter int MIN_RST_TICKS = 200
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_ctl_off,
  input logic fund_rst,
  input logic opmode_rst_req,
  input logic pwr_en,
  input logic port_rst_n
);
  localparam int MIN_CYC = MIN_RST_TICKS * TICK_DIV;

  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= '0;
    else if (port_rst_n) low_cnt <= '0;
    else                 low_cnt <= low_cnt + 1'b1;
  end

  AST_RST_WHILE_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> !port_rst_n); // R1
  AST_POWER_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_rst_n) |-> $past(pwr_en)); // R3
  AST_RESET_BEFORE_UNPOWER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(!port_rst_n)); // R4
  AST_OFF_REQ_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ctl_off |=> !port_rst_n); // R4
  AST_FUND_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    fund_rst |=> !port_rst_n); // R7
  AST_OPMODE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    opmode_rst_req |=> !port_rst_n); // R7
  AST_MIN_RESET_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_rst_n) |-> (low_cnt >= MIN_CYC)); // R8
endmodule

bind slot_pwr_seq slot_pwr_seq_chk #(
  .TICK_DIV     (TICK_DIV),
  .MIN_RST_TICKS(MIN_RST_TICKS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pwr_ctl_off   (pwr_ctl_off),
  .fund_rst      (fund_rst),
  .opmode_rst_req(opmode_rst_req),
  .pwr_en        (pwr_en),
  .port_rst_n    (port_rst_n)
);

// File: tb/slot_pwr_seq_bench.sv
module slot_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 2;
  localparam int MINT = 200;
  localparam int DW   = 8;
  localparam int HOLD_LO = MINT * DIV;
  localparam int HOLD_HI = (MINT + 1) * DIV + 6;

  localparam int EV_PE_UP = 0, EV_PE_DN = 1, EV_REL = 2, EV_AST = 3;

  typedef struct {
    int    code;
    bit    from_stim;
    int    lo;
    int    hi;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic pwr_ctl_off, mode_pg, pwr_good_n, fund_rst, opmode_rst_req;
  logic [DW-1:0] dly_pwr2rst, dly_rst2pwr;
  logic pwr_en, port_rst_n, slot_on;

  int  cyc = 0;
  int  stim_cyc = 0;
  int  last_edge = 0;
  int  n_checks = 0;
  int  n_errors = 0;
  bit  mon_en = 1'b0;
  bit  done_flag = 1'b0;
  logic pe_q, rn_q;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  slot_pwr_seq #(.TICK_DIV(DIV), .MIN_RST_TICKS(MINT), .DLY_W(DW)) u_slot_pwr_seq (
    .clk(clk), .rst_n(rst_n), .pwr_ctl_off(pwr_ctl_off), .mode_pg(mode_pg),
    .dly_pwr2rst(dly_pwr2rst), .dly_rst2pwr(dly_rst2pwr), .pwr_good_n(pwr_good_n),
    .fund_rst(fund_rst), .opmode_rst_req(opmode_rst_req),
    .pwr_en(pwr_en), .port_rst_n(port_rst_n), .slot_on(slot_on)
  );

  function automatic string ev_name(int c);
    case (c)
      EV_PE_UP: return "pwr_en_rise";
      EV_PE_DN: return "pwr_en_fall";
      EV_REL:   return "rst_release";
      default:  return "rst_assert";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string act, string exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %s expected %s (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(int code, bit from_stim, int lo, int hi, string tag);
    exp_t e;
    e.code = code; e.from_stim = from_stim; e.lo = lo; e.hi = hi; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic observe(int code);
    exp_t e;
    int   el;
    if (expq.size() == 0) begin
      check(1'b0, "unexpected", ev_name(code), "no edge");
    end else begin
      e  = expq.pop_front();
      el = cyc - (e.from_stim ? stim_cyc : last_edge);
      check(e.code == code, e.tag, ev_name(code), ev_name(e.code));
      check(el >= e.lo && el <= e.hi, e.tag, $sformatf("%0d cycles", el),
            $sformatf("%0d..%0d cycles", e.lo, e.hi));
    end
    check(slot_on == port_rst_n, "R10", $sformatf("slot_on=%0b", slot_on),
          $sformatf("%0b", port_rst_n));
    last_edge = cyc;
  endtask

  // monitor: compares each output edge with the next expected item
  always @(negedge clk) begin
    if (mon_en) begin
      if (pwr_en !== pe_q)     observe(pwr_en ? EV_PE_UP : EV_PE_DN);
      if (port_rst_n !== rn_q) observe(port_rst_n ? EV_REL : EV_AST);
      pe_q = pwr_en;
      rn_q = port_rst_n;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stim_mark();
    @(negedge clk);
    stim_cyc = cyc;
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", "timeout", "finish");
    report();
  end

  initial begin
    rst_n = 1'b0; pwr_ctl_off = 1'b1; mode_pg = 1'b0; pwr_good_n = 1'b1;
    fund_rst = 1'b0; opmode_rst_req = 1'b0; dly_pwr2rst = 8'd3; dly_rst2pwr = 8'd2;
    wait_cyc(5);
    check(pwr_en == 1'b0 && port_rst_n == 1'b0 && slot_on == 1'b0, "R1",
          $sformatf("%0b%0b%0b", pwr_en, port_rst_n, slot_on), "000");
    rst_n = 1'b1;
    pe_q = 1'b0; rn_q = 1'b0; mon_en = 1'b1;
    wait_cyc(600);

    // R2 R3: power-enable mode, power good held bad and ignored
    stim_mark(); pwr_ctl_off = 1'b0;
    push(EV_PE_UP, 1, 1, 1, "R2");
    push(EV_REL, 0, 3*DIV, 4*DIV+4, "R3");
    wait_cyc(40);
    check(slot_on == 1'b1, "R10", $sformatf("%0b", slot_on), "1");

    // R7 R8: one-cycle operating-mode request
    stim_mark(); opmode_rst_req = 1'b1;
    push(EV_AST, 1, 1, 1, "R7");
    push(EV_REL, 0, HOLD_LO, HOLD_HI, "R8");
    @(negedge clk); opmode_rst_req = 1'b0;
    wait_cyc(450);

    // R7 R8: held fundamental reset, power untouched
    stim_mark(); fund_rst = 1'b1;
    push(EV_AST, 1, 1, 1, "R7");
    wait_cyc(30);
    check(pwr_en == 1'b1 && port_rst_n == 1'b0, "R7",
          $sformatf("%0b%0b", pwr_en, port_rst_n), "10");
    stim_mark(); fund_rst = 1'b0;
    push(EV_REL, 1, HOLD_LO, HOLD_HI, "R8");
    wait_cyc(450);

    // R4: power-down ordering
    dly_rst2pwr = 8'd4;
    stim_mark(); pwr_ctl_off = 1'b1;
    push(EV_AST, 1, 1, 1, "R4");
    push(EV_PE_DN, 0, 4*DIV, 5*DIV+4, "R4");
    wait_cyc(500);

    // R11: zero delay fields give a single tick
    dly_pwr2rst = 8'd0; dly_rst2pwr = 8'd0;
    stim_mark(); pwr_ctl_off = 1'b0;
    push(EV_PE_UP, 1, 1, 1, "R2");
    push(EV_REL, 0, 1, DIV+4, "R11");
    wait_cyc(20);
    stim_mark(); pwr_ctl_off = 1'b1;
    push(EV_AST, 1, 1, 1, "R4");
    push(EV_PE_DN, 0, 1, DIV+4, "R11");
    wait_cyc(450);

    // R5: power-good mode waits for the supply
    mode_pg = 1'b1; dly_pwr2rst = 8'd5; dly_rst2pwr = 8'd2;
    stim_mark(); pwr_ctl_off = 1'b0;
    push(EV_PE_UP, 1, 1, 1, "R2");
    wait_cyc(60);
    check(port_rst_n == 1'b0, "R5", $sformatf("%0b", port_rst_n), "0");
    stim_mark(); pwr_good_n = 1'b0;
    push(EV_REL, 1, 5*DIV+1, 6*DIV+6, "R5");
    wait_cyc(40);

    // R6: supply loss while on
    stim_mark(); pwr_good_n = 1'b1;
    push(EV_AST, 1, 2, 5, "R6");
    wait_cyc(30);
    check(pwr_en == 1'b1, "R6", $sformatf("%0b", pwr_en), "1");
    stim_mark(); pwr_ctl_off = 1'b1;
    push(EV_PE_DN, 1, 2*DIV+1, 3*DIV+5, "R4");
    wait_cyc(450);

    // R9: abort while waiting for power good
    stim_mark(); pwr_ctl_off = 1'b0;
    push(EV_PE_UP, 1, 1, 1, "R9");
    wait_cyc(20);
    stim_mark(); pwr_ctl_off = 1'b1;
    push(EV_PE_DN, 1, 2*DIV+1, 3*DIV+5, "R9");
    wait_cyc(30);

    // R9: abort during the power-to-reset wait
    mode_pg = 1'b0; dly_pwr2rst = 8'd50;
    stim_mark(); pwr_ctl_off = 1'b0;
    push(EV_PE_UP, 1, 1, 1, "R9");
    wait_cyc(20);
    stim_mark(); pwr_ctl_off = 1'b1;
    push(EV_PE_DN, 1, 2*DIV+1, 3*DIV+5, "R9");
    wait_cyc(200);
    check(port_rst_n == 1'b0 && pwr_en == 1'b0, "R9",
          $sformatf("%0b%0b", pwr_en, port_rst_n), "00");

    check(expq.size() == 0, "missing", $sformatf("%0d pending", expq.size()), "0 pending");
    report();
  end
endmodule